// File: doc/BRIEF.md
# Link Packet CRC-16 Checker with Embedded-CRC Removal

This block sits in the receive path of a serial packet link. Packets arrive as a stream of 32-bit words. Start and end markers delimit each packet. Byte 0 of a packet sits in bits 31:24 of its first word, and every packet is a whole number of words. Each packet carries a CRC-16 in its last two meaningful bytes. When the packet has an odd number of 16-bit halves, two zero bytes follow that CRC.

A packet whose header and payload exceed 80 bytes carries a second CRC. That CRC is placed directly after byte 80, in the upper half of word 20. The block checks both CRCs. A failure of either one is reported on the end-of-packet word. When `cfg_strip` is high, the embedded CRC is removed, and a half-word holding register moves every later byte up by two positions. The final CRC and any pad bytes are always forwarded.

Both stream edges use valid/ready. A word transfers on a clock edge where valid and ready are both high. The block holds `out_*` stable while `out_valid` is high and `out_ready` is low. `in_ready` depends only on the output register state and `out_ready`. It never depends on `in_valid`. When the embedded CRC is stripped, the block adds one extra output word at the end of the packet, and `in_ready` drops for that one cycle. `cfg_strip` must only change between packets.

Top module: `lp_crc_strip`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_keep`, `out_sop`, `out_eop` and `out_crc_err` hold their values on the next cycle.
- R2: A packet of at most 21 words (input word 20, counted from 0 at `in_sop`, is absent or carries `in_eop`) is forwarded word for word, with `out_keep` = 4'b1111 and the start and end markers on the first and last words.
- R3: The CRC is computed as follows. The polynomial is x^16+x^12+x^5+1 (0x1021), the register starts at 0xFFFF, and bytes are fed most significant bit first, byte 0 first. A bad final CRC sets `out_crc_err` on the end-of-packet word. The final CRC covers every earlier byte, including any embedded CRC, and any zero pad is also fed through the register.
- R4: In a longer packet, the upper half of input word 20 is the CRC of bytes 0 to 79. A mismatch there is kept and reported through `out_crc_err` on the end-of-packet word.
- R5: With `cfg_strip` high, the two embedded CRC bytes are removed and all later bytes move up by two byte lanes. The final output word carries two bytes with `out_keep` = 4'b1100 (bits 31:16 valid, bits 15:0 zero). It is the only output word of the packet with a partial `out_keep`.
- R6: With `cfg_strip` low, a long packet is forwarded unchanged, embedded CRC included, with `out_keep` = 4'b1111 on every word.
- R7: `out_crc_err` is high only on a valid word that also has `out_eop` high.
- R8: The final CRC and any trailing zero pad are forwarded. The output byte count equals the input byte count, minus two when the embedded CRC is stripped.
- R9: The top six bits of byte 0 are taken as zero by the CRC check, so their value does not change `out_crc_err`.
- R10: Synchronous active-high `rst` clears `out_valid`, discards any partly received packet, and leaves `in_ready` high in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_strip | input | 1 | 1: remove the CRC after byte 80; 0: pass it through |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input word, byte 0 in bits 31:24 |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 32 | Output word |
| out_keep | output | 4 | Byte enables, bit 3 for bits 31:24 |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_crc_err | output | 1 | Either CRC of this packet failed; valid with out_eop |

## Verification
Different internal faults show up at different times:

| Internal fault | Where it shows at the ports | When |
|---|---|---|
| Corrupt running CRC register or byte mask | Wrong `out_crc_err` | Only at the end-of-packet word, possibly up to about 40 words after the fault |
| Lost embedded-CRC flag | Wrong `out_crc_err` | At the end of that packet |
| Wrong word counter or holding register | Shifted or duplicated bytes on `out_data` | From word 20 onward |
| Missing flush | Missing final half-word, wrong `out_keep` | At the end of the packet |

The stimulus therefore compares every output word and the error flag for packets whose lengths sit on both sides of the 21-word boundary. It covers both strip settings, a corrupted CRC in each position, and a stalled sink. A corrupted CRC in one position must not be masked by a correct CRC in the other.

// File: rtl/lpcrc_pkg.sv
package lpcrc_pkg;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
  localparam int unsigned HALF_W     = WORD_W / 2;
  localparam int unsigned KEEP_W     = WORD_BYTES;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  localparam logic [KEEP_W-1:0] KEEP_FULL = '1;
  localparam logic [KEEP_W-1:0] KEEP_HALF = {{(KEEP_W/2){1'b1}}, {(KEEP_W/2){1'b0}}};

  // Advance the CRC register over 16 data bits, most significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                             input logic [15:0] din);
    logic [15:0] r;
    logic        fb;
    r = cur;
    for (int k = 15; k >= 0; k--) begin
      fb = r[15] ^ din[k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/lpcrc_word_crc.sv
// Combinational CRC over one 32-bit word.
// Also gives the residue after the upper half, which is where the embedded
// CRC ends.
module lpcrc_word_crc
  import lpcrc_pkg::*;
#(
  parameter int unsigned MASK_BITS = 6
) (
  input  logic [15:0]       crc_in,
  input  logic [WORD_W-1:0] word,
  input  logic              mask_hdr,
  output logic [15:0]       crc_mid,
  output logic [15:0]       crc_full
);

  logic [HALF_W-1:0] hi_eff;

  generate
    if (MASK_BITS == 0) begin : g_nomask
      assign hi_eff = word[WORD_W-1:HALF_W];
    end else begin : g_mask
      localparam logic [HALF_W-1:0] HDR_KEEP = {HALF_W{1'b1}} >> MASK_BITS;
      assign hi_eff = mask_hdr ? (word[WORD_W-1:HALF_W] & HDR_KEEP)
                               : word[WORD_W-1:HALF_W];
    end
  endgenerate

  always_comb begin
    crc_mid  = crc16_step(crc_in, hi_eff);
    crc_full = crc16_step(crc_mid, word[HALF_W-1:0]);
  end

endmodule

// File: rtl/lpcrc_track.sv
// Per-packet state: word index, running CRC, and the sticky embedded-CRC error.
module lpcrc_track
  import lpcrc_pkg::*;
#(
  parameter int unsigned EMB_BYTES = 80,
  parameter int unsigned MASK_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [WORD_W-1:0] in_word,
  output logic              at_emb,
  output logic              end_bad
);

  localparam int unsigned EMB_WORD = EMB_BYTES / WORD_BYTES;
  localparam int unsigned IDX_MAX  = EMB_WORD + 1;
  localparam int unsigned IDX_W    = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0] idx_q, idx_cur;
  logic [15:0]      crc_q, crc_cur, crc_mid, crc_full;
  logic             err_q, err_cur;

  assign idx_cur = in_sop ? '0 : idx_q;
  assign crc_cur = in_sop ? CRC_SEED : crc_q;

  lpcrc_word_crc #(.MASK_BITS(MASK_BITS)) u_crc (
    .crc_in   (crc_cur),
    .word     (in_word),
    .mask_hdr (in_sop),
    .crc_mid  (crc_mid),
    .crc_full (crc_full)
  );

  // The embedded CRC exists only when the packet runs past word EMB_WORD.
  assign at_emb  = (idx_cur == IDX_W'(EMB_WORD)) && !in_eop;
  assign err_cur = (in_sop ? 1'b0 : err_q) | (at_emb && (crc_mid != 16'h0000));
  assign end_bad = err_cur | (crc_full != 16'h0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      crc_q <= CRC_SEED;
      err_q <= 1'b0;
    end else if (take) begin
      crc_q <= crc_full;
      err_q <= err_cur;
      idx_q <= (idx_cur == IDX_W'(IDX_MAX)) ? idx_cur : idx_cur + 1'b1;
    end
  end

endmodule

// File: rtl/lpcrc_align.sv
// Output register with a half-word holding register for realignment.
module lpcrc_align
  import lpcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              drop,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              end_bad,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              flush_pend,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [KEEP_W-1:0] out_keep,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_crc_err
);

  logic              shift_q, flush_q, flush_err_q;
  logic [HALF_W-1:0] hold_q;

  assign slot_free  = !out_valid || out_ready;
  assign flush_pend = flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_keep    <= '0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_crc_err <= 1'b0;
      shift_q     <= 1'b0;
      flush_q     <= 1'b0;
      flush_err_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      if (slot_free) out_valid <= 1'b0;
      if (flush_q && slot_free) begin
        out_valid   <= 1'b1;
        out_data    <= {hold_q, {HALF_W{1'b0}}};
        out_keep    <= KEEP_HALF;
        out_sop     <= 1'b0;
        out_eop     <= 1'b1;
        out_crc_err <= flush_err_q;
        flush_q     <= 1'b0;
        shift_q     <= 1'b0;
      end else if (take) begin
        if (drop) begin
          hold_q  <= in_word[HALF_W-1:0];
          shift_q <= 1'b1;
        end else if (shift_q) begin
          out_valid   <= 1'b1;
          out_data    <= {hold_q, in_word[WORD_W-1:HALF_W]};
          out_keep    <= KEEP_FULL;
          out_sop     <= 1'b0;
          out_eop     <= 1'b0;
          out_crc_err <= 1'b0;
          hold_q      <= in_word[HALF_W-1:0];
          if (in_eop) begin
            flush_q     <= 1'b1;
            flush_err_q <= end_bad;
          end
        end else begin
          out_valid   <= 1'b1;
          out_data    <= in_word;
          out_keep    <= KEEP_FULL;
          out_sop     <= in_sop;
          out_eop     <= in_eop;
          out_crc_err <= in_eop && end_bad;
        end
      end
    end
  end

endmodule

// File: rtl/lp_crc_strip.sv
module lp_crc_strip
  import lpcrc_pkg::*;
#(
  parameter int unsigned EMB_BYTES = 80,
  parameter int unsigned MASK_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_strip,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [KEEP_W-1:0] out_keep,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_crc_err
);

  logic take, at_emb, end_bad, slot_free, flush_pend;

  assign in_ready = slot_free && !flush_pend;
  assign take     = in_valid && in_ready;

  lpcrc_track #(.EMB_BYTES(EMB_BYTES), .MASK_BITS(MASK_BITS)) u_track (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .in_sop  (in_sop),
    .in_eop  (in_eop),
    .in_word (in_data),
    .at_emb  (at_emb),
    .end_bad (end_bad)
  );

  lpcrc_align u_align (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .drop        (at_emb && cfg_strip),
    .in_word     (in_data),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .end_bad     (end_bad),
    .out_ready   (out_ready),
    .slot_free   (slot_free),
    .flush_pend  (flush_pend),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_keep    (out_keep),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_crc_err (out_crc_err)
  );

endmodule

// File: rtl/lpcrc_sva.sv
module lpcrc_sva
  import lpcrc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [KEEP_W-1:0] out_keep,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_crc_err
);

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep)
      && $stable(out_sop) && $stable(out_eop) && $stable(out_crc_err));

  a_r7_err_on_eop: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_crc_err |-> out_eop);

  a_r5_partial_only_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_keep != KEEP_FULL) |-> out_eop && (out_keep == KEEP_HALF) && !out_sop);

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);

endmodule

bind lp_crc_strip lpcrc_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_keep    (out_keep),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .out_crc_err (out_crc_err)
);

// File: tb/lp_crc_strip_tb.sv
`timescale 1ns/1ps
module lp_crc_strip_tb;

  typedef struct packed {
    logic [7:0] nbytes;
    logic [7:0] seed;
    logic       strip;
    logic [1:0] bad;    // 0 none, 1 final CRC, 2 embedded CRC
    logic       bp;
    logic       ack;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{8'd12,  8'd3,  1'b1, 2'd0, 1'b0, 1'b0},
    '{8'd30,  8'd5,  1'b1, 2'd0, 1'b1, 1'b0},
    '{8'd78,  8'd9,  1'b1, 2'd0, 1'b0, 1'b0},
    '{8'd80,  8'd11, 1'b1, 2'd0, 1'b0, 1'b0},
    '{8'd82,  8'd13, 1'b1, 2'd0, 1'b0, 1'b0},
    '{8'd84,  8'd17, 1'b1, 2'd0, 1'b1, 1'b0},
    '{8'd100, 8'd19, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'd150, 8'd23, 1'b1, 2'd0, 1'b1, 1'b0},
    '{8'd40,  8'd29, 1'b1, 2'd1, 1'b0, 1'b0},
    '{8'd120, 8'd31, 1'b1, 2'd2, 1'b0, 1'b0},
    '{8'd120, 8'd37, 1'b0, 2'd2, 1'b1, 1'b0},
    '{8'd96,  8'd41, 1'b1, 2'd0, 1'b0, 1'b1},
    '{8'd20,  8'd43, 1'b0, 2'd1, 1'b0, 1'b1},
    '{8'd150, 8'd47, 1'b0, 2'd1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_strip = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sop, out_eop, out_crc_err;
  logic [31:0] out_data;
  logic [3:0]  out_keep;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lp_crc_strip u_dut (
    .clk(clk), .rst(rst), .cfg_strip(cfg_strip),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_sop(out_sop), .out_eop(out_eop),
    .out_crc_err(out_crc_err)
  );

  logic [7:0]  pb [256];
  logic [7:0]  ob [256];
  logic [31:0] inw [64];
  int nin, nout_b;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] crc8(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        f;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      f = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (f) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    logic [15:0] c;
    logic [7:0]  b, hb;
    int n, m;
    c = 16'hFFFF;
    n = 0;
    for (int i = 0; i < int'(v.nbytes); i++) begin
      b = 8'(int'(v.seed) * 7 + i * 13 + (i >> 3));
      if (i == 0) b = v.ack ? (b | 8'hFC) : (b & 8'h03);
      hb = (i == 0) ? (b & 8'h03) : b;
      pb[n] = b; n++;
      c = crc8(c, hb);
      if (i == 79 && v.nbytes > 8'd80) begin
        logic [15:0] e;
        e = c ^ ((v.bad == 2'd2) ? 16'h0100 : 16'h0000);
        pb[n] = e[15:8]; pb[n+1] = e[7:0]; n += 2;
        c = crc8(crc8(c, e[15:8]), e[7:0]);
      end
    end
    c = c ^ ((v.bad == 2'd1) ? 16'h0008 : 16'h0000);
    pb[n] = c[15:8]; pb[n+1] = c[7:0]; n += 2;
    if (n % 4 != 0) begin pb[n] = 8'h00; pb[n+1] = 8'h00; n += 2; end
    nin = n / 4;
    for (int w = 0; w < nin; w++) inw[w] = {pb[4*w], pb[4*w+1], pb[4*w+2], pb[4*w+3]};
    m = 0;
    for (int j = 0; j < n; j++) begin
      if (!(v.strip && v.nbytes > 8'd80 && (j == 80 || j == 81))) begin
        ob[m] = pb[j]; m++;
      end
    end
    nout_b = m;
    for (int j = m; j < m + 4; j++) ob[j] = 8'h00;
  endtask

  task automatic run_pkt(input vec_t v);
    int ip, op, ocnt;
    logic done;
    logic [31:0] ew;
    logic [3:0]  ek;
    logic        ee;
    string tag, etag;
    build(v);
    cfg_strip = v.strip;
    tag  = (v.nbytes > 8'd80) ? (v.strip ? "R5" : "R6") : "R2";
    if (v.bp) tag = {tag, "/R1"};
    etag = (v.bad == 2'd2) ? "R4" : (v.ack ? "R9" : "R3");
    ip = 0; op = 0; ocnt = 0; done = 1'b0;
    while (!done) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = v.bp ? lfsr[0] : 1'b1;
      in_valid  = (ip < nin);
      in_data   = (ip < nin) ? inw[ip] : 32'h0;
      in_sop    = (ip == 0);
      in_eop    = (ip == nin - 1);
      #1;
      if (out_valid && out_ready) begin
        ew = {ob[op], ob[op+1], ob[op+2], ob[op+3]};
        ee = (op + 4 >= nout_b);
        ek = (nout_b - op >= 4) ? 4'b1111 : 4'b1100;
        check(tag, {out_data, out_keep, out_sop, out_eop} == {ew, ek, (op == 0), ee},
              64'({out_data, out_keep, out_sop, out_eop}), 64'({ew, ek, (op == 0), ee}));
        if (!out_eop) check("R7", out_crc_err == 1'b0, 64'(out_crc_err), 64'(0));
        else begin
          check(etag, out_crc_err == (v.bad != 2'd0), 64'(out_crc_err), 64'(v.bad != 2'd0));
          done = 1'b1;
        end
        op += 4;
        ocnt += (out_keep == 4'b1111) ? 4 : 2;
      end
      if (in_valid && in_ready) ip++;
    end
    check("R8", ocnt == nout_b, 64'(ocnt), 64'(nout_b));
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R10", !out_valid && in_ready, 64'({out_valid, in_ready}), 64'(2'b01));

    for (int t = 0; t < NVEC; t++) run_pkt(VECS[t]);

    // Reset in the middle of a long packet with the sink stalled.
    build(VECS[7]);
    cfg_strip = 1'b1;
    out_ready = 1'b0;
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = inw[w]; in_sop = (w == 0); in_eop = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk); #1;
    check("R10", !out_valid && in_ready, 64'({out_valid, in_ready}), 64'(2'b01));
    run_pkt(VECS[0]);
    run_pkt(VECS[9]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule